// File: doc/BRIEF.md
# Shared Memory Ownership Controller

This block decides who may touch two shared data RAM blocks and one shared program RAM: the host CPU or a coprocessor. The host writes a small configuration word that maps each RAM into the coprocessor's space. The controller then passes or refuses each access request from the CPU, the debug port and the coprocessor. The RAM arrays, arbitration between simultaneous accesses and the bus protocols sit outside the block. The block only produces a grant per requester and a fault flag for refused requests.

A configuration write does not act at once. It passes through a short register pipeline and governs access gating from the second clock edge after the write. Software therefore knows exactly when ownership changes hands. A data RAM that has been handed to the coprocessor can be re-opened to the CPU through a per-block CPU-enable bit. Once the program RAM is handed over, the CPU can reach it only through debug accesses.

Top module: `mem_owner_ctrl`

## Requirements
- R1: A synchronous active-high reset clears the configuration word and every output. After reset both RAM kinds belong to the CPU.
- R2: The configuration word is 1+2N bits wide, with N = 2 data blocks. Bit 0 maps the program RAM to the coprocessor. Bit 1+i maps data block i to the coprocessor. Bit 1+N+i is the CPU-enable bit of data block i. A value of 1 means set.
- R3: While data block i is not mapped, a CPU request to it is granted and a coprocessor request to it is refused.
- R4: While data block i is mapped, a coprocessor request is granted. A CPU request is granted only if that block's CPU-enable bit is 1. The CPU-enable bit has no effect while the block is unmapped.
- R5: While the program map bit is 0, CPU program requests are granted and coprocessor program requests are refused. While it is 1, the reverse holds. The two program grants are never high together.
- R6: A debug request to the program RAM is granted whatever the program map bit is.
- R7: A request sampled at a clock edge produces its grant on the registered output during the following cycle. The grant lasts one cycle per sampled request.
- R8: A configuration write sampled at edge T governs requests sampled at edge T+2 and later. Requests sampled at edges T and T+1 still see the previous configuration.
- R9: `access_fault` is high for the one cycle after an edge at which at least one request was refused. Otherwise it is low.
- R10: No grant is ever high unless its request was sampled at the preceding edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 1+2N | Configuration word to write |
| cpu_dreq | input | N | CPU request, one bit per data block |
| cpu_preq | input | 1 | CPU program RAM request |
| dbg_preq | input | 1 | Debug program RAM request |
| cop_dreq | input | N | Coprocessor request, one bit per data block |
| cop_preq | input | 1 | Coprocessor program RAM request |
| cpu_dgnt | output | N | CPU data grants |
| cpu_pgnt | output | 1 | CPU program grant |
| dbg_pgnt | output | 1 | Debug program grant |
| cop_dgnt | output | N | Coprocessor data grants |
| cop_pgnt | output | 1 | Coprocessor program grant |
| access_fault | output | 1 | One-cycle flag for a refused request |

## Verification
The assertions check the following on every cycle:
- the reset state;
- that no grant appears without a request;
- that the two program grants never overlap;
- that debug requests are always granted;
- that a fault only follows a request;
- that grants hold steady when requests hold and no write occurred three edges back.

Only the bench's scenarios can show that the ownership rules pick the right requester for each configuration. They also show that the CPU-enable bit is ignored on an unmapped block, and that a write changes the outcome at exactly the second edge and not earlier. The bench establishes these with directed sequences around writes and a long seeded random run compared against a model of the requirements.

// File: rtl/mown_pkg.sv
package mown_pkg;
  typedef enum logic {
    OWN_HOST = 1'b0,
    OWN_COP  = 1'b1
  } owner_e;

  localparam int PROG_BIT = 0;

  function automatic int map_bit(input int blk);
    return 1 + blk;
  endfunction

  function automatic int cpuen_bit(input int blk, input int nblk);
    return 1 + nblk + blk;
  endfunction
endpackage

// File: rtl/mown_cfg_pipe.sv
module mown_cfg_pipe #(
  parameter int W      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] active
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stage_q[0] <= '0;
    else if (we) stage_q[0] <= wdata;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_delay
    always_ff @(posedge clk) begin
      if (rst) stage_q[s] <= '0;
      else stage_q[s] <= stage_q[s-1];
    end
  end

  assign active = stage_q[STAGES-1];
endmodule

// File: rtl/mown_dram_gate.sv
module mown_dram_gate
  import mown_pkg::*;
(
  input  owner_e owner,
  input  logic   cpu_en,
  input  logic   cpu_req,
  input  logic   cop_req,
  output logic   cpu_ok,
  output logic   cop_ok,
  output logic   refused
);
  always_comb begin
    cop_ok  = cop_req && (owner == OWN_COP);
    cpu_ok  = cpu_req && ((owner == OWN_HOST) || cpu_en);
    refused = (cpu_req && !cpu_ok) || (cop_req && !cop_ok);
  end
endmodule

// File: rtl/mown_prog_gate.sv
module mown_prog_gate
  import mown_pkg::*;
(
  input  owner_e owner,
  input  logic   cpu_req,
  input  logic   dbg_req,
  input  logic   cop_req,
  output logic   cpu_ok,
  output logic   dbg_ok,
  output logic   cop_ok,
  output logic   refused
);
  always_comb begin
    cpu_ok  = cpu_req && (owner == OWN_HOST);
    cop_ok  = cop_req && (owner == OWN_COP);
    dbg_ok  = dbg_req;
    refused = (cpu_req && !cpu_ok) || (cop_req && !cop_ok);
  end
endmodule

// File: rtl/mem_owner_ctrl.sv
module mem_owner_ctrl
  import mown_pkg::*;
#(
  parameter int N      = 2,
  parameter int STAGES = 2,
  localparam int CW    = 1 + 2 * N
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic [CW-1:0] cfg_wdata,
  input  logic [N-1:0]  cpu_dreq,
  input  logic          cpu_preq,
  input  logic          dbg_preq,
  input  logic [N-1:0]  cop_dreq,
  input  logic          cop_preq,
  output logic [N-1:0]  cpu_dgnt,
  output logic          cpu_pgnt,
  output logic          dbg_pgnt,
  output logic [N-1:0]  cop_dgnt,
  output logic          cop_pgnt,
  output logic          access_fault
);
  logic [CW-1:0] cfg_act;
  logic [N-1:0]  cpu_d_ok, cop_d_ok, d_refused;
  logic          cpu_p_ok, dbg_p_ok, cop_p_ok, p_refused;

  mown_cfg_pipe #(.W(CW), .STAGES(STAGES)) u_pipe (
    .clk    (clk),
    .rst    (rst),
    .we     (cfg_we),
    .wdata  (cfg_wdata),
    .active (cfg_act)
  );

  for (genvar b = 0; b < N; b++) begin : g_dram
    mown_dram_gate u_gate (
      .owner   (owner_e'(cfg_act[map_bit(b)])),
      .cpu_en  (cfg_act[cpuen_bit(b, N)]),
      .cpu_req (cpu_dreq[b]),
      .cop_req (cop_dreq[b]),
      .cpu_ok  (cpu_d_ok[b]),
      .cop_ok  (cop_d_ok[b]),
      .refused (d_refused[b])
    );
  end

  mown_prog_gate u_prog (
    .owner   (owner_e'(cfg_act[PROG_BIT])),
    .cpu_req (cpu_preq),
    .dbg_req (dbg_preq),
    .cop_req (cop_preq),
    .cpu_ok  (cpu_p_ok),
    .dbg_ok  (dbg_p_ok),
    .cop_ok  (cop_p_ok),
    .refused (p_refused)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_dgnt     <= '0;
      cop_dgnt     <= '0;
      cpu_pgnt     <= 1'b0;
      dbg_pgnt     <= 1'b0;
      cop_pgnt     <= 1'b0;
      access_fault <= 1'b0;
    end else begin
      cpu_dgnt     <= cpu_d_ok;
      cop_dgnt     <= cop_d_ok;
      cpu_pgnt     <= cpu_p_ok;
      dbg_pgnt     <= dbg_p_ok;
      cop_pgnt     <= cop_p_ok;
      access_fault <= (|d_refused) || p_refused;
    end
  end
endmodule

// File: rtl/mown_checker.sv
module mown_checker #(
  parameter int N = 2,
  localparam int CW = 1 + 2 * N
) (
  input logic          clk,
  input logic          rst,
  input logic          cfg_we,
  input logic [CW-1:0] cfg_wdata,
  input logic [N-1:0]  cpu_dreq,
  input logic          cpu_preq,
  input logic          dbg_preq,
  input logic [N-1:0]  cop_dreq,
  input logic          cop_preq,
  input logic [N-1:0]  cpu_dgnt,
  input logic          cpu_pgnt,
  input logic          dbg_pgnt,
  input logic [N-1:0]  cop_dgnt,
  input logic          cop_pgnt,
  input logic          access_fault
);
  logic [2*N+2:0] reqs, gnts;
  assign reqs = {cpu_dreq, cop_dreq, cpu_preq, dbg_preq, cop_preq};
  assign gnts = {cpu_dgnt, cop_dgnt, cpu_pgnt, dbg_pgnt, cop_pgnt};

  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (gnts == '0 && !access_fault));

  assert_grant_needs_req_R10: assert property (@(posedge clk) disable iff (rst)
    (gnts & ~$past(reqs)) == '0);

  assert_prog_exclusive_R5: assert property (@(posedge clk) disable iff (rst)
    !(cpu_pgnt && cop_pgnt));

  assert_debug_granted_R6: assert property (@(posedge clk) disable iff (rst)
    ($past(dbg_preq) && !$past(rst)) |-> dbg_pgnt);

  assert_fault_after_req_R9: assert property (@(posedge clk) disable iff (rst)
    access_fault |-> ($past(reqs) != '0));

  assert_grants_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2) && !$past(rst, 3) &&
     $past(reqs) == $past(reqs, 2) && !$past(cfg_we, 3)) |-> $stable(gnts));
endmodule

bind mem_owner_ctrl mown_checker #(.N(N)) u_chk (
  .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
  .cpu_dreq(cpu_dreq), .cpu_preq(cpu_preq), .dbg_preq(dbg_preq),
  .cop_dreq(cop_dreq), .cop_preq(cop_preq),
  .cpu_dgnt(cpu_dgnt), .cpu_pgnt(cpu_pgnt), .dbg_pgnt(dbg_pgnt),
  .cop_dgnt(cop_dgnt), .cop_pgnt(cop_pgnt), .access_fault(access_fault)
);

// File: tb/mem_owner_ctrl_test.sv
module mem_owner_ctrl_test;
  localparam int N  = 2;
  localparam int CW = 1 + 2 * N;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_we = 1'b0;
  logic [CW-1:0] cfg_wdata = '0;
  logic [N-1:0]  cpu_dreq = '0, cop_dreq = '0;
  logic          cpu_preq = 1'b0, dbg_preq = 1'b0, cop_preq = 1'b0;
  logic [N-1:0]  cpu_dgnt, cop_dgnt;
  logic          cpu_pgnt, dbg_pgnt, cop_pgnt, access_fault;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [CW-1:0] cfg_now = '0, cfg_prev = '0;

  always #10 clk = ~clk;

  mem_owner_ctrl #(.N(N)) uut (.*);

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // One cycle: drive, let the edge sample, compare against the requirement model.
  task automatic step(logic we, logic [CW-1:0] wd, logic [N-1:0] cd, logic cp,
                      logic dp, logic [N-1:0] od, logic op);
    logic [CW-1:0] use_cfg;
    logic [N-1:0] map, en, e_cpu, e_cop;
    logic e_cpup, e_copp, e_flt;
    @(negedge clk);
    cfg_we = we; cfg_wdata = wd; cpu_dreq = cd; cpu_preq = cp;
    dbg_preq = dp; cop_dreq = od; cop_preq = op;
    @(posedge clk);
    use_cfg  = cfg_prev;          // R8: write from two edges back is in force
    cfg_prev = cfg_now;
    if (we) cfg_now = wd;
    map = use_cfg[N:1];           // R2 field layout
    en  = use_cfg[2*N:N+1];
    e_cpu  = cd & (~map | en);
    e_cop  = od & map;
    e_cpup = cp & ~use_cfg[0];
    e_copp = op & use_cfg[0];
    e_flt  = |(cd & ~e_cpu) | |(od & ~e_cop) | (cp & ~e_cpup) | (op & ~e_copp);
    #5;
    for (int b = 0; b < N; b++) begin
      chk(map[b] ? "R4 cpu data" : "R3 cpu data", 8'(cpu_dgnt[b]), 8'(e_cpu[b]));
      chk(map[b] ? "R4 cop data" : "R3 cop data", 8'(cop_dgnt[b]), 8'(e_cop[b]));
    end
    chk("R5 program", {6'd0, cpu_pgnt, cop_pgnt}, {6'd0, e_cpup, e_copp});
    chk("R6 debug", 8'(dbg_pgnt), 8'(dp));
    chk("R9 fault", 8'(access_fault), 8'(e_flt));
  endtask

  initial begin
    int seed;
    seed = $urandom(32'h5eed_0042);
    repeat (3) @(posedge clk);
    #5;
    chk("R1 reset grants", {cpu_dgnt, cop_dgnt, cpu_pgnt, dbg_pgnt, cop_pgnt}, 8'd0);
    chk("R1 reset fault", 8'(access_fault), 8'd0);
    @(negedge clk); rst = 1'b0;

    // R1: after reset CPU owns everything
    step(0, '0, 2'b11, 1, 0, 2'b11, 1);
    chk("R1 cpu owns data", 8'(cpu_dgnt), 8'h3);
    chk("R1 cop refused", 8'(cop_dgnt), 8'h0);

    // R8 / R7: write mapping block 0 while CPU keeps requesting it
    step(1, 5'b00010, 2'b01, 0, 0, 2'b00, 0);
    chk("R8 edge T uses old", 8'(cpu_dgnt[0]), 8'd1);
    step(0, '0, 2'b01, 0, 0, 2'b00, 0);
    chk("R8 edge T+1 uses old", 8'(cpu_dgnt[0]), 8'd1);
    step(0, '0, 2'b01, 0, 0, 2'b00, 0);
    chk("R8 edge T+2 uses new", 8'(cpu_dgnt[0]), 8'd0);
    chk("R8 fault on refusal", 8'(access_fault), 8'd1);

    // R4: CPU-enable re-opens mapped block 0
    step(1, 5'b01010, 2'b01, 0, 0, 2'b01, 0);
    step(0, '0, 2'b01, 0, 0, 2'b01, 0);
    step(0, '0, 2'b01, 0, 0, 2'b01, 0);
    chk("R4 cpu-enable grants cpu", 8'(cpu_dgnt[0]), 8'd1);
    chk("R4 cop still granted", 8'(cop_dgnt[0]), 8'd1);

    // R4: CPU-enable on unmapped block 1 changes nothing
    step(1, 5'b10000, 2'b10, 0, 0, 2'b10, 0);
    step(0, '0, 2'b10, 0, 0, 2'b10, 0);
    step(0, '0, 2'b10, 0, 0, 2'b10, 0);
    chk("R4 enable ignored cpu", 8'(cpu_dgnt[1]), 8'd1);
    chk("R4 enable ignored cop", 8'(cop_dgnt[1]), 8'd0);

    // R5 / R6: program mapped, debug still served
    step(1, 5'b00001, 0, 1, 1, 0, 1);
    step(0, '0, 0, 1, 1, 0, 1);
    step(0, '0, 0, 1, 1, 0, 1);
    chk("R5 cpu program refused", 8'(cpu_pgnt), 8'd0);
    chk("R5 cop program granted", 8'(cop_pgnt), 8'd1);
    chk("R6 debug when mapped", 8'(dbg_pgnt), 8'd1);

    // R10 / R9: idle requests give nothing
    step(0, '0, 0, 0, 0, 0, 0);
    chk("R10 no request no grant", {cpu_dgnt, cop_dgnt, cpu_pgnt, dbg_pgnt, cop_pgnt}, 8'd0);
    chk("R9 idle no fault", 8'(access_fault), 8'd0);

    // R2 / R3 / R7: seeded random mix, including back-to-back writes
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] r;
      r = $urandom;
      step(r[2:0] == 3'd0, CW'($urandom), r[9:8], r[10], r[11], r[13:12], r[14]);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule